// File: doc/BRIEF.md
# Hart Interrupt Pending and Arbitration Unit

This block keeps the machine-level interrupt state of a 32-bit hart that runs at machine, supervisor and user privilege. It holds the pending set, the enable set and the delegation set. Every cycle it decides whether an interrupt trap is due and, if so, which one. External interrupt sources change the pending set only through raise and lower masks. Software reaches the state through CSR reads and writes at the standard pending, enable, supervisor-pending and delegation addresses.

The arbitration applies a global enable to each delegation target, relative to the current privilege level. Interrupts aimed at a level above the current one always fire. Interrupts aimed at the current level need that level's global bit. Interrupts aimed at a lower level never fire. The lowest-numbered eligible interrupt wins. The trap request is a registered strobe, and it carries a cause code with the interrupt flag in bit 31. A separate wake pulse releases a hart that is sleeping in wait-for-interrupt. The wake pulse does not depend on privilege or on the global bits.

Top module: `hart_irq_arb`

## Requirements
- R1: A raise mask ORs its bits into the pending set. A lower mask clears its bits. When both masks name the same bit in one cycle, the bit ends cleared. Only bits 1, 3, 5, 7, 9 and 11 (mask 0xAAA) can ever be pending.
- R2: A write to address 0x344 (machine pending) changes only bit 1 (supervisor software) and bit 5 (supervisor timer). Bits 3, 7 and 11 keep their value. A read of 0x344 returns the whole pending set.
- R3: A read of 0x144 (supervisor pending) returns the pending set ANDed with the delegation set. A write to 0x144 changes only the pending bits that are set in the delegation set.
- R4: Writes to 0x304 (enable) and 0x303 (delegation) store the written data ANDed with 0xAAA, and reads of these addresses return the stored value. A read of any other address returns zero.
- R5: A pending, enabled, non-delegated interrupt is eligible when the privilege is below machine (U=2'b00, S=2'b01), or when the machine global bit is set. With privilege M=2'b11 and the machine global bit clear, it is not eligible.
- R6: A pending, enabled, delegated interrupt is eligible in U mode, and in S mode when the supervisor global bit is set. It is never eligible in M mode.
- R7: When any interrupt is eligible, `take_irq` is high in the next cycle. `irq_cause` then equals 0x8000_0000 plus the index of the lowest eligible bit. Otherwise both are zero.
- R8: When a CSR write and an external raise or lower occur in the same cycle, the external masks are applied after the write and win on every bit.
- R9: After `wfi_enter`, a raise that leaves (pending AND enable) nonzero produces a one-cycle `wake` pulse in the next cycle, whatever the privilege and global bits. `wake` then stays low until `wfi_enter` is given again. A raise of a non-enabled bit gives no pulse. A raise while not sleeping gives no pulse.
- R10: Reset clears the pending, enable and delegation sets and leaves `take_irq`, `irq_cause` and `wake` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 32 | External raise mask |
| src_clr | input | 32 | External lower mask |
| csr_req | input | 1 | CSR access valid |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| priv | input | 2 | Current privilege: U=00, S=01, M=11 |
| gie_m | input | 1 | Machine global interrupt enable |
| gie_s | input | 1 | Supervisor global interrupt enable |
| wfi_enter | input | 1 | Hart enters wait-for-interrupt |
| take_irq | output | 1 | Interrupt trap request |
| irq_cause | output | 32 | Trap cause code |
| wake | output | 1 | Wake pulse for a sleeping hart |

## Verification
Two functions can land in the same cycle: a software write to the pending set and an external raise or lower mask. The bench provokes this by issuing a write to 0x344 while `src_set` and `src_clr` are active in the same cycle. It judges the result by reading the pending set back, expecting the external masks to have been applied over the written value. A second overlap occurs when a raise arrives while the hart sleeps and the privilege rules would block the trap. The bench checks that `wake` fires while `take_irq` stays low.

// File: rtl/hart_irq_pkg.sv
// Package: shared constants and types for the hart interrupt unit.
// Assumes a 32-bit hart with the six standard M/S interrupt bits.
package hart_irq_pkg;
    localparam int XLEN   = 32;
    localparam int CSR_AW = 12;
    localparam int IDX_W  = $clog2(XLEN);

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    localparam int BIT_SSW = 1;
    localparam int BIT_MSW = 3;
    localparam int BIT_STM = 5;
    localparam int BIT_MTM = 7;
    localparam int BIT_SEX = 9;
    localparam int BIT_MEX = 11;

    localparam logic [XLEN-1:0] LEGAL_MASK =
        (XLEN'(1) << BIT_SSW) | (XLEN'(1) << BIT_MSW) | (XLEN'(1) << BIT_STM) |
        (XLEN'(1) << BIT_MTM) | (XLEN'(1) << BIT_SEX) | (XLEN'(1) << BIT_MEX);
    localparam logic [XLEN-1:0] MIP_SW_MASK =
        (XLEN'(1) << BIT_SSW) | (XLEN'(1) << BIT_STM);
    localparam logic [XLEN-1:0] MIP_RO_MASK =
        (XLEN'(1) << BIT_MSW) | (XLEN'(1) << BIT_MTM) | (XLEN'(1) << BIT_MEX);

    localparam logic [CSR_AW-1:0] ADDR_SIP    = 12'h144;
    localparam logic [CSR_AW-1:0] ADDR_MDELEG = 12'h303;
    localparam logic [CSR_AW-1:0] ADDR_MENA   = 12'h304;
    localparam logic [CSR_AW-1:0] ADDR_MIP    = 12'h344;
endpackage

// File: rtl/irq_state.sv
// Module: irq_state
// Holds the pending, enable and delegation sets and decodes CSR accesses.
// Assumes at most one CSR access per cycle; external masks win over writes.
module irq_state
    import hart_irq_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = CSR_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src_set,
    input  logic [W-1:0]  src_clr,
    input  logic          csr_req,
    input  logic          csr_we,
    input  logic [AW-1:0] csr_addr,
    input  logic [W-1:0]  csr_wdata,
    output logic [W-1:0]  csr_rdata,
    output logic [W-1:0]  pend_q,
    output logic [W-1:0]  ena_q,
    output logic [W-1:0]  deleg_q,
    output logic [W-1:0]  pend_nxt
);
    logic          wr;
    logic          hit_mip, hit_sip, hit_ena, hit_deleg;
    logic [W-1:0]  sw_mask;
    logic [W-1:0]  pend_sw;

    // Address decode shared by read and write paths.
    always_comb begin
        wr        = csr_req && csr_we;
        hit_mip   = (csr_addr == ADDR_MIP);
        hit_sip   = (csr_addr == ADDR_SIP);
        hit_ena   = (csr_addr == ADDR_MENA);
        hit_deleg = (csr_addr == ADDR_MDELEG);
    end

    // Next pending value: software write first, then external masks on top.
    always_comb begin
        sw_mask = '0;
        if (wr && hit_mip) sw_mask = MIP_SW_MASK;
        else if (wr && hit_sip) sw_mask = deleg_q;
        pend_sw  = (pend_q & ~sw_mask) | (csr_wdata & sw_mask);
        pend_nxt = ((pend_sw | src_set) & ~src_clr) & LEGAL_MASK;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            ena_q   <= '0;
            deleg_q <= '0;
        end else begin
            pend_q <= pend_nxt;
            if (wr && hit_ena)   ena_q   <= csr_wdata & LEGAL_MASK;
            if (wr && hit_deleg) deleg_q <= csr_wdata & LEGAL_MASK;
        end
    end

    // Read multiplexer over the current state.
    always_comb begin
        csr_rdata = '0;
        if (hit_mip)        csr_rdata = pend_q;
        else if (hit_sip)   csr_rdata = pend_q & deleg_q;
        else if (hit_ena)   csr_rdata = ena_q;
        else if (hit_deleg) csr_rdata = deleg_q;
    end

    // R1: raised (and not lowered) legal bits are pending after the edge.
    p_raise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_set & ~src_clr & LEGAL_MASK)) |=>
        ((pend_q & $past(src_set & ~src_clr & LEGAL_MASK)) == $past(src_set & ~src_clr & LEGAL_MASK)));

    // R1: lowered bits are never pending after the edge.
    p_lower_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |=> ((pend_q & $past(src_clr)) == '0));

    // R2: a machine-pending write leaves the machine bits untouched.
    p_mip_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && csr_addr == ADDR_MIP && src_set == '0 && src_clr == '0)
        |=> ((pend_q & MIP_RO_MASK) == ($past(pend_q) & MIP_RO_MASK)));

    // R3: a supervisor-pending write leaves non-delegated bits untouched.
    p_sip_nondeleg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && csr_addr == ADDR_SIP && src_set == '0 && src_clr == '0)
        |=> ((pend_q & ~$past(deleg_q)) == ($past(pend_q) & ~$past(deleg_q))));
endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Applies per-target global enables relative to privilege and picks the
// lowest eligible interrupt; the result is registered as a trap request.
// Assumes pending/enable/delegation inputs come from registers.
module irq_pick
    import hart_irq_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IDX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] ena_i,
    input  logic [W-1:0] deleg_i,
    input  logic [1:0]   priv_i,
    input  logic         gie_m_i,
    input  logic         gie_s_i,
    output logic         take_q,
    output logic [W-1:0] cause_q
);
    logic          m_open, s_open;
    logic [W-1:0]  cand;
    logic [IW-1:0] idx;

    // Per-target enable relative to the current privilege.
    always_comb begin
        m_open = (priv_i != PRIV_M) || gie_m_i;
        s_open = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && gie_s_i);
        cand   = pend_i & ena_i & ((~deleg_i & {W{m_open}}) | (deleg_i & {W{s_open}}));
    end

    // Lowest-index search: later (lower) hits overwrite earlier ones.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end

    // Register the trap request and its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            take_q  <= |cand;
            cause_q <= (|cand) ? {1'b1, {(W-1-IW){1'b0}}, idx} : '0;
        end
    end

    // R7: a request always carries the interrupt flag and a legal index.
    p_cause_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> (cause_q[W-1] && LEGAL_MASK[cause_q[IW-1:0]]));

    // R5: machine mode with its global bit clear never requests.
    p_m_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == PRIV_M && !gie_m_i) |=> !take_q);

    // R6: in machine mode a delegated interrupt is never chosen.
    p_m_no_deleg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == PRIV_M) |=> (!take_q || !$past(deleg_i[cause_q[IW-1:0]])));
endmodule

// File: rtl/irq_wfi.sv
// Module: irq_wfi
// Tracks the wait-for-interrupt state and issues a one-cycle wake pulse
// when a raise leaves an enabled interrupt pending. Ignores privilege.
module irq_wfi (
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_enter,
    input  logic raise_any,
    input  logic ena_hit,
    output logic wake_q
);
    logic sleep_q;

    // Sleep flag and wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            if (sleep_q && raise_any && ena_hit) begin
                sleep_q <= 1'b0;
                wake_q  <= 1'b1;
            end else if (wfi_enter) begin
                sleep_q <= 1'b1;
            end
        end
    end

    // R9: a wake pulse only follows a sleeping cycle.
    p_wake_from_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(sleep_q));

    // R9: wake lasts a single cycle.
    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);
endmodule

// File: rtl/hart_irq_arb.sv
// Module: hart_irq_arb (top)
// Interrupt pending/enable state, arbitration and wake logic for one hart.
// Assumes one CSR access per cycle and synchronous inputs.
module hart_irq_arb
    import hart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   src_set,
    input  logic [XLEN-1:0]   src_clr,
    input  logic              csr_req,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic [1:0]        priv,
    input  logic              gie_m,
    input  logic              gie_s,
    input  logic              wfi_enter,
    output logic              take_irq,
    output logic [XLEN-1:0]   irq_cause,
    output logic              wake
);
    logic [XLEN-1:0] pend_q, ena_q, deleg_q, pend_nxt;
    logic            raise_any, ena_hit;

    irq_state #(.W(XLEN), .AW(CSR_AW)) u_state (
        .clk(clk), .rst_n(rst_n),
        .src_set(src_set), .src_clr(src_clr),
        .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .pend_q(pend_q), .ena_q(ena_q), .deleg_q(deleg_q), .pend_nxt(pend_nxt)
    );

    irq_pick #(.W(XLEN), .IW(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend_q), .ena_i(ena_q), .deleg_i(deleg_q),
        .priv_i(priv), .gie_m_i(gie_m), .gie_s_i(gie_s),
        .take_q(take_irq), .cause_q(irq_cause)
    );

    // Wake condition: a raise this cycle leaves an enabled bit pending.
    always_comb begin
        raise_any = |(src_set & LEGAL_MASK);
        ena_hit   = |(pend_nxt & ena_q);
    end

    irq_wfi u_wfi (
        .clk(clk), .rst_n(rst_n),
        .wfi_enter(wfi_enter), .raise_any(raise_any), .ena_hit(ena_hit),
        .wake_q(wake)
    );
endmodule

// File: tb/hart_irq_arb_test.sv
module hart_irq_arb_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_set, src_clr, csr_wdata, csr_rdata, irq_cause;
    logic        csr_req, csr_we, gie_m, gie_s, wfi_enter, take_irq, wake;
    logic [11:0] csr_addr;
    logic [1:0]  priv;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #4 clk = ~clk;

    hart_irq_arb uut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv(priv),
        .gie_m(gie_m), .gie_s(gie_s), .wfi_enter(wfi_enter),
        .take_irq(take_irq), .irq_cause(irq_cause), .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        csr_req = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        tick();
        csr_req = 0; csr_we = 0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
        csr_req = 1; csr_we = 0; csr_addr = a;
        #1 d = csr_rdata;
        csr_req = 0;
    endtask

    task automatic raise(input logic [31:0] m);
        src_set = m; tick(); src_set = '0;
    endtask

    task automatic lower(input logic [31:0] m);
        src_clr = m; tick(); src_clr = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        csr_rd(12'h344, d); chk("R10 pending", d, 0);
        csr_rd(12'h304, d); chk("R10 enable", d, 0);
        csr_rd(12'h303, d); chk("R10 deleg", d, 0);
        chk("R10 take", {31'b0, take_irq}, 0);
        chk("R10 cause", irq_cause, 0);
        chk("R10 wake", {31'b0, wake}, 0);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        raise(32'h888); csr_rd(12'h344, d); chk("R1 raise", d, 32'h888);
        raise(32'hFFFF_FFFF); csr_rd(12'h344, d); chk("R1 legal only", d, 32'hAAA);
        lower(32'h0A0); csr_rd(12'h344, d); chk("R1 lower", d, 32'hA0A);
        src_set = 32'h2; src_clr = 32'h2; tick(); src_set = '0; src_clr = '0;
        csr_rd(12'h344, d); chk("R1 clear wins", d, 32'hA08);
        lower(32'hFFFF_FFFF);
    endtask

    task automatic t_mip_write();
        logic [31:0] d;
        raise(32'h888);
        csr_wr(12'h344, 32'h0); csr_rd(12'h344, d); chk("R2 m bits kept", d, 32'h888);
        csr_wr(12'h344, 32'hFFFF_FFFF); csr_rd(12'h344, d); chk("R2 s bits only", d, 32'h8AA);
        lower(32'hFFFF_FFFF);
    endtask

    task automatic t_sip();
        logic [31:0] d;
        csr_wr(12'h303, 32'h222);
        raise(32'hA00);
        csr_rd(12'h144, d); chk("R3 sip read", d, 32'h200);
        csr_wr(12'h144, 32'hFFF); csr_rd(12'h344, d); chk("R3 sip write set", d, 32'hA22);
        csr_wr(12'h144, 32'h0); csr_rd(12'h344, d); chk("R3 sip write clear", d, 32'h800);
        csr_rd(12'h144, d); chk("R3 sip read zero", d, 32'h0);
        lower(32'hFFFF_FFFF);
        csr_wr(12'h303, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        csr_wr(12'h304, 32'hFFFF_FFFF); csr_rd(12'h304, d); chk("R4 enable mask", d, 32'hAAA);
        csr_wr(12'h303, 32'h1234); csr_rd(12'h303, d); chk("R4 deleg mask", d, 32'h220);
        csr_rd(12'h300, d); chk("R4 other addr", d, 32'h0);
        csr_wr(12'h303, 32'h0);
    endtask

    task automatic t_menable();
        csr_wr(12'h304, 32'hAAA);
        raise(32'h080);
        priv = 2'b11; gie_m = 0; tick(); tick();
        chk("R5 M closed", {31'b0, take_irq}, 0);
        gie_m = 1; tick(); tick();
        chk("R5 M open take", {31'b0, take_irq}, 1);
        chk("R7 cause 7", irq_cause, 32'h8000_0007);
        priv = 2'b01; gie_m = 0; tick(); tick();
        chk("R5 S above", {31'b0, take_irq}, 1);
        lower(32'hFFFF_FFFF); tick();
        chk("R7 idle", {31'b0, take_irq}, 0);
    endtask

    task automatic t_senable();
        csr_wr(12'h303, 32'h222);
        raise(32'h020);
        priv = 2'b11; gie_m = 1; gie_s = 1; tick(); tick();
        chk("R6 M never", {31'b0, take_irq}, 0);
        priv = 2'b01; gie_s = 0; gie_m = 0; tick(); tick();
        chk("R6 S closed", {31'b0, take_irq}, 0);
        gie_s = 1; tick(); tick();
        chk("R6 S open", irq_cause, 32'h8000_0005);
        priv = 2'b00; gie_s = 0; tick(); tick();
        chk("R6 U always", irq_cause, 32'h8000_0005);
        lower(32'hFFFF_FFFF);
        csr_wr(12'h303, 32'h0);
    endtask

    task automatic t_priority();
        priv = 2'b00;
        raise(32'hAAA); tick();
        chk("R7 lowest 1", irq_cause, 32'h8000_0001);
        lower(32'h002); tick();
        chk("R7 lowest 3", irq_cause, 32'h8000_0003);
        csr_wr(12'h304, 32'h800); tick();
        chk("R7 only 11", irq_cause, 32'h8000_000B);
        lower(32'hFFFF_FFFF); tick();
        chk("R7 cause cleared", irq_cause, 0);
    endtask

    task automatic t_merge();
        logic [31:0] d;
        src_set = 32'h800; src_clr = 32'h002;
        csr_wr(12'h344, 32'hFFFF);
        src_set = '0; src_clr = '0;
        csr_rd(12'h344, d); chk("R8 external wins", d, 32'h820);
        lower(32'hFFFF_FFFF);
    endtask

    task automatic t_wfi();
        csr_wr(12'h304, 32'h800);
        priv = 2'b11; gie_m = 0;
        raise(32'h800);
        chk("R9 awake no pulse", {31'b0, wake}, 0);
        lower(32'hFFFF_FFFF);
        wfi_enter = 1; tick(); wfi_enter = 0;
        raise(32'h008);
        chk("R9 not enabled", {31'b0, wake}, 0);
        src_set = 32'h800; tick(); src_set = '0;
        chk("R9 wake", {31'b0, wake}, 1);
        chk("R9 no trap in M closed", {31'b0, take_irq}, 0);
        tick();
        chk("R9 one cycle", {31'b0, wake}, 0);
        raise(32'h800);
        chk("R9 stays awake", {31'b0, wake}, 0);
        lower(32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; src_set = '0; src_clr = '0; csr_req = 0; csr_we = 0;
        csr_addr = '0; csr_wdata = '0; priv = 2'b11; gie_m = 0; gie_s = 0;
        wfi_enter = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_mip_write();
        t_sip();
        t_regs();
        t_menable();
        t_senable();
        t_priority();
        t_merge();
        t_wfi();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule